// File: doc/BRIEF.md
# Register-Amount Shifter with Carry Flag

This block shifts or rotates a data word by an amount read from a register, and produces the carry flag that a processor's flag-setting shift instructions would leave behind. One of four operations is chosen per use: logical left, logical right, arithmetic right or rotate right. Only the low byte of the amount word counts. An amount of 0 through 255 is therefore possible, and each operation has its own carry rule for amounts of zero, exactly one word width, and more than one word width.

The caller presents the data word, the amount word, the operation code and the current carry flag. The result, the new carry and a carry-write strobe appear one clock later from output registers. The strobe tells the flag logic whether the carry came from the shift, or whether it is only the old carry passed through unchanged. The output registers can be dropped with a parameter, which makes the path purely combinational.

Top module: `reg_shifter_cf`

## Requirements
- R1: Only amount bits [7:0] take part. The upper 24 bits of the amount word have no effect on the result, the carry or the strobe.
- R2: With an effective amount of 0, the result equals the data word and the carry equals the incoming carry, for every operation.
- R3: Operation code 2'b00 is logical left. For n in 1..31, the result is data shifted left by n and the carry is data bit (32-n). For n=32, the result is 0 and the carry is data bit 0. For n>32, the result is 0 and the carry is 0.
- R4: Operation code 2'b01 is logical right. For n in 1..31, the result is data shifted right by n and the carry is data bit (n-1). For n=32, the result is 0 and the carry is data bit 31. For n>32, both are 0.
- R5: Operation code 2'b10 is arithmetic right. For n in 1..31, the vacated bits fill with data bit 31 and the carry is data bit (n-1). For n>=32, every result bit and the carry equal data bit 31.
- R6: Operation code 2'b11 is rotate right by r = n mod 32. When r is 0 but n is nonzero, the result is the data word unchanged and the carry is data bit 31.
- R7: For a rotate with r nonzero, the result is data rotated right by r and the carry is data bit (r-1).
- R8: The carry-write strobe is 1 exactly when the effective amount is nonzero, for any operation.
- R9: With the output registers present, the outputs follow the inputs after one clock. While reset is high, the result, the carry and the strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 32 | Word to shift or rotate |
| amount_i | input | 32 | Amount register value; low byte used |
| op_i | input | 2 | Operation: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted or rotated word |
| carry_o | output | 1 | New carry flag value |
| carry_we_o | output | 1 | High when carry_o comes from the shift |

## Verification
The bench runs every operation over all 256 effective amounts with several data patterns and both carry polarities. Expected values come from a bit-by-bit model.

- An amount of exactly 32 is where a design that treats the amount as 5 bits goes wrong: it returns the input unchanged, or takes the carry from the wrong end.
- Amounts above 32 catch a logical shift that leaks a nonzero carry, and an arithmetic shift that stops filling with the sign bit.
- Rotates by nonzero multiples of 32 catch a design that copies the zero-amount rule and keeps the old carry instead of taking bit 31.
- Amounts with random upper bits expose a decoder that looks past the low byte.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_op_e;
endpackage

// File: rtl/rsh_amount_decode.sv
// Reduces the amount register to its effective byte and rotate count.
module rsh_amount_decode #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8,
  parameter int WORD_W   = 32
) (
  input  logic [WORD_W-1:0]        amount_i,
  output logic [AMT_BITS-1:0]      amt_o,
  output logic [$clog2(WIDTH)-1:0] rot_o,
  output logic                     zero_o
);
  localparam int ROT_W = $clog2(WIDTH);

  assign amt_o  = amount_i[AMT_BITS-1:0];
  assign rot_o  = amount_i[ROT_W-1:0];
  assign zero_o = (amount_i[AMT_BITS-1:0] == '0);
endmodule

// File: rtl/rsh_shift_core.sv
// Combinational shift and rotate, with the carry rules for each operation.
module rsh_shift_core
  import rsh_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8
) (
  input  logic [WIDTH-1:0]         data_i,
  input  logic [AMT_BITS-1:0]      amt_i,
  input  logic [$clog2(WIDTH)-1:0] rot_i,
  input  logic                     zero_i,
  input  logic [1:0]               op_i,
  input  logic                     carry_i,
  output logic [WIDTH-1:0]         result_o,
  output logic                     carry_o,
  output logic                     carry_we_o
);
  // One guard bit beside the word catches the last bit shifted out.
  logic [WIDTH:0]        lsl_ext;
  logic [WIDTH:0]        lsr_ext;
  logic signed [WIDTH:0] asr_ext;
  logic [WIDTH-1:0]      ror_res;

  assign lsl_ext = {1'b0, data_i} << amt_i;
  assign lsr_ext = {data_i, 1'b0} >> amt_i;
  assign asr_ext = $signed({data_i, 1'b0}) >>> amt_i;
  assign ror_res = (data_i >> rot_i) | (data_i << (WIDTH - int'(rot_i)));

  always_comb begin
    result_o   = data_i;
    carry_o    = carry_i;
    carry_we_o = 1'b0;
    if (!zero_i) begin
      carry_we_o = 1'b1;
      unique case (sh_op_e'(op_i))
        SH_LSL: begin
          result_o = lsl_ext[WIDTH-1:0];
          carry_o  = lsl_ext[WIDTH];
        end
        SH_LSR: begin
          result_o = lsr_ext[WIDTH:1];
          carry_o  = lsr_ext[0];
        end
        SH_ASR: begin
          result_o = asr_ext[WIDTH:1];
          carry_o  = asr_ext[0];
        end
        SH_ROR: begin
          // For rot 0 this gives the word unchanged, with bit 31 as carry.
          result_o = ror_res;
          carry_o  = ror_res[WIDTH-1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsh_out_stage.sv
// Optional output register, synchronous active-high reset.
module rsh_out_stage #(
  parameter int WIDTH   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] result_d,
  input  logic             carry_d,
  input  logic             we_d,
  output logic [WIDTH-1:0] result_q,
  output logic             carry_q,
  output logic             we_q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result_q <= '0;
          carry_q  <= 1'b0;
          we_q     <= 1'b0;
        end else begin
          result_q <= result_d;
          carry_q  <= carry_d;
          we_q     <= we_d;
        end
      end
    end else begin : g_comb
      assign result_q = result_d;
      assign carry_q  = carry_d;
      assign we_q     = we_d;
    end
  endgenerate
endmodule

// File: rtl/reg_shifter_cf.sv
module reg_shifter_cf #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] amount_i,
  input  logic [1:0]       op_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             carry_we_o
);
  localparam int ROT_W = $clog2(WIDTH);

  logic [AMT_BITS-1:0] amt;
  logic [ROT_W-1:0]    rot;
  logic                amt_zero;
  logic [WIDTH-1:0]    res_c;
  logic                carry_c;
  logic                we_c;

  rsh_amount_decode #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS), .WORD_W(WIDTH)) u_dec (
    .amount_i (amount_i),
    .amt_o    (amt),
    .rot_o    (rot),
    .zero_o   (amt_zero)
  );

  rsh_shift_core #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_core (
    .data_i     (data_i),
    .amt_i      (amt),
    .rot_i      (rot),
    .zero_i     (amt_zero),
    .op_i       (op_i),
    .carry_i    (carry_i),
    .result_o   (res_c),
    .carry_o    (carry_c),
    .carry_we_o (we_c)
  );

  rsh_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
    .clk      (clk),
    .rst      (rst),
    .result_d (res_c),
    .carry_d  (carry_c),
    .we_d     (we_c),
    .result_q (result_o),
    .carry_q  (carry_o),
    .we_q     (carry_we_o)
  );
endmodule

// File: rtl/rsh_checks.sv
module rsh_checks #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8,
  parameter bit OUT_REG  = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] amount_i,
  input logic [1:0]       op_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             carry_we_o
);
  localparam int ROT_W = $clog2(WIDTH);
  localparam logic [AMT_BITS-1:0] W_AMT = AMT_BITS'(WIDTH);

  // High once the previous edge sampled reset low.
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  generate
    if (OUT_REG) begin : g_chk
      p_zero_hold_r2: assert property (@(posedge clk) disable iff (rst)
        armed && ($past(amount_i[AMT_BITS-1:0]) == '0) |->
          (result_o == $past(data_i)) && (carry_o == $past(carry_i)));

      p_we_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> (carry_we_o == ($past(amount_i[AMT_BITS-1:0]) != '0)));

      p_lsl_big_r3: assert property (@(posedge clk) disable iff (rst)
        armed && ($past(op_i) == 2'b00) && ($past(amount_i[AMT_BITS-1:0]) > W_AMT) |->
          (result_o == '0) && !carry_o);

      p_lsr_exact_r4: assert property (@(posedge clk) disable iff (rst)
        armed && ($past(op_i) == 2'b01) && ($past(amount_i[AMT_BITS-1:0]) == W_AMT) |->
          (result_o == '0) && (carry_o == $past(data_i[WIDTH-1])));

      p_asr_fill_r5: assert property (@(posedge clk) disable iff (rst)
        armed && ($past(op_i) == 2'b10) && ($past(amount_i[AMT_BITS-1:0]) >= W_AMT) |->
          (result_o == {WIDTH{$past(data_i[WIDTH-1])}}) && (carry_o == $past(data_i[WIDTH-1])));

      p_ror_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        armed && ($past(op_i) == 2'b11) && ($past(amount_i[AMT_BITS-1:0]) != '0) &&
        ($past(amount_i[ROT_W-1:0]) == '0) |->
          (result_o == $past(data_i)) && (carry_o == $past(data_i[WIDTH-1])));

      p_rst_clear_r9: assert property (@(posedge clk)
        $past(rst) && armed == 1'b0 && rst |-> (result_o == '0) && !carry_o && !carry_we_o);
    end
  endgenerate
endmodule

bind reg_shifter_cf rsh_checks #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS), .OUT_REG(OUT_REG)) u_rsh_checks (
  .clk        (clk),
  .rst        (rst),
  .data_i     (data_i),
  .amount_i   (amount_i),
  .op_i       (op_i),
  .carry_i    (carry_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .carry_we_o (carry_we_o)
);

// File: tb/tb_reg_shifter_cf.sv
module tb_reg_shifter_cf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] data_i = '0;
  logic [31:0] amount_i = '0;
  logic [1:0]  op_i = 2'b00;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  logic        carry_we_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  reg_shifter_cf dut (
    .clk(clk), .rst(rst), .data_i(data_i), .amount_i(amount_i),
    .op_i(op_i), .carry_i(carry_i), .result_o(result_o),
    .carry_o(carry_o), .carry_we_o(carry_we_o)
  );

  // Bit-by-bit reference model written from the requirements.
  function automatic logic [32:0] model(input logic [1:0] op, input int n,
                                        input logic [31:0] d, input logic cin);
    logic [31:0] r;
    logic        c;
    int          k;
    r = d;
    c = cin;
    if (n != 0) begin
      case (op)
        2'b00: begin  // R3
          for (int i = 0; i < 32; i++) r[i] = (i >= n) ? d[i-n] : 1'b0;
          c = (n <= 32) ? d[32-n] : 1'b0;
        end
        2'b01: begin  // R4
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? d[i+n] : 1'b0;
          c = (n <= 32) ? d[n-1] : 1'b0;
        end
        2'b10: begin  // R5
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? d[i+n] : d[31];
          c = (n >= 32) ? d[31] : d[n-1];
        end
        default: begin  // R6 / R7
          k = n % 32;
          for (int i = 0; i < 32; i++) r[i] = d[(i+k)%32];
          c = (k == 0) ? d[31] : d[k-1];
        end
      endcase
    end
    return {c, r};
  endfunction

  function automatic string tag_of(input logic [1:0] op, input int n);
    if (n == 0) return "R2";
    case (op)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return ((n % 32) == 0) ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ec, input logic ewe);
    n_checks++;
    if (result_o !== er || carry_o !== ec || carry_we_o !== ewe) begin
      n_fail++;
      $display("FAIL %s: got res=%h c=%b we=%b, expected res=%h c=%b we=%b",
               req, result_o, carry_o, carry_we_o, er, ec, ewe);
    end
  endtask

  // Drive at a falling edge; the output register loads at the next rising
  // edge; sample at the falling edge after that.
  task automatic run(input string req, input logic [1:0] op, input logic [31:0] amt,
                     input logic [31:0] d, input logic cin);
    logic [32:0] e;
    int n;
    n = int'(amt[7:0]);
    e = model(op, n, d, cin);
    op_i = op; amount_i = amt; data_i = d; carry_i = cin;
    @(negedge clk);
    check(req, e[31:0], e[32], n != 0);  // R8 strobe checked with every case
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] pats [6];
    logic [31:0] lf;
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'hFFFF_FFFF;
    pats[4] = 32'h1234_5678;
    pats[5] = 32'hC000_0003;

    // R9: reset holds outputs at zero even with live inputs
    data_i = 32'hDEAD_BEEF; amount_i = 32'd5; op_i = 2'b11; carry_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // Full sweep: all operations, all 256 effective amounts
    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 4; o++)
        for (int n = 0; n < 256; n++)
          run(tag_of(2'(o), n), 2'(o), 32'(n), pats[p], 1'((p + n) & 1));

    // R2: zero amount keeps both carry polarities, every operation
    for (int o = 0; o < 4; o++) begin
      run("R2", 2'(o), 32'h0, 32'h0F0F_1234, 1'b1);
      run("R2", 2'(o), 32'h0, 32'hF0F0_4321, 1'b0);
    end

    // R1: upper amount bits must be ignored
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run("R1", lf[1:0], {lf[31:8] | 24'h1, 8'(i)}, ~lf ^ 32'h5A5A_0000, lf[3]);
    end

    // R9: one-cycle latency, back-to-back distinct inputs
    run("R9", 2'b00, 32'd4, 32'h0000_00FF, 1'b0);
    run("R9", 2'b01, 32'd4, 32'h0000_00FF, 1'b0);

    done = 1;
    finish_run();
  end
endmodule